// File: doc/BRIEF.md
# Threshold Data FIFO with DMA Request Routing

This block is a circular word buffer between a register-bus data port and the card data path of a storage-card host. The bus side writes and reads words through a data port. The card side has its own push and pop strobes. The buffer is 32 words of 16 bits by default. A registered occupancy count drives two threshold comparators: one watches for a high level while data is being received, and one watches for a low level while data is being sent.

A direction input selects which comparator is live. When a comparator's condition holds, the result goes either to a DMA request line or to a status flag. A per-direction DMA enable in a configuration register makes that choice. All threshold outputs are suppressed while the block is idle, meaning no transfer is active and the buffer is empty. A command-start pulse empties the buffer so that a new data command begins at slot zero.

Top module: `tfifo_dma`

## Requirements
- R1: After reset the occupancy is 0, all four threshold outputs are low, and the configuration reads back 16'h1F00: high threshold 31, low threshold 0, both DMA enables off.
- R2: Words leave the buffer in the order they entered. The read and write pointers wrap modulo the depth, so order holds across the wrap. `rd_data` always shows the oldest stored word.
- R3: A push while the occupancy equals the depth (32) is discarded. This holds even if a pop happens in the same cycle. Occupancy never exceeds the depth.
- R4: A bus read or card pop while the buffer is empty does not pop. The occupancy stays 0, and `rd_data` keeps showing the entry at the read pointer.
- R5: With `dir_rx`=1, an occupancy strictly greater than the high threshold (cfg bits 12:8) asserts `rx_dma_req` if RX DMA is enabled (cfg bit 15), and `full_flag` otherwise. `tx_dma_req` and `empty_flag` stay low.
- R6: With `dir_rx`=0, an occupancy strictly less than the low threshold (cfg bits 4:0) asserts `tx_dma_req` if TX DMA is enabled (cfg bit 7), and `empty_flag` otherwise. `rx_dma_req` and `full_flag` stay low.
- R7: While `xfer_active`=0 and the buffer is empty, all four threshold outputs are low. A non-empty buffer keeps the thresholds live even with `xfer_active`=0.
- R8: The configuration reads back the written value masked to bits 15, 12:8, 7 and 4:0. A configuration write that sets a DMA enable clears that direction's flag from the next cycle on.
- R9: A `cmd_start` pulse sets the occupancy to 0 and both pointers to slot 0. Any push or pop in the same cycle is ignored.
- R10: If a bus write and a card push coincide, one word is stored, and it is the bus word. A push and a pop in the same cycle on a non-full, non-empty buffer leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Configuration readback |
| bus_wr | input | 1 | Bus push strobe |
| bus_wdata | input | 16 | Bus push word |
| bus_rd | input | 1 | Bus pop strobe |
| card_push | input | 1 | Card-side push strobe |
| card_wdata | input | 16 | Card-side push word |
| card_pop | input | 1 | Card-side pop strobe |
| rd_data | output | 16 | Oldest stored word (head) |
| dir_rx | input | 1 | 1 = receive (card to bus), 0 = transmit |
| xfer_active | input | 1 | A data transfer is in progress |
| cmd_start | input | 1 | Start of a data command; empties the buffer |
| level | output | 6 | Current occupancy |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| full_flag | output | 1 | Almost-full status flag |
| empty_flag | output | 1 | Almost-empty status flag |

## Verification
An off-by-one in the occupancy count shows up within one cycle. The thresholds are swept across every level from 0 to 32, so a miscounted level moves a request or flag edge by one step, and the bench sees it at the exact level where the edge should sit. A pointer that wraps wrongly or advances on a rejected push or pop corrupts `rd_data` on the next pop, and the ordered data patterns expose it. A comparator that is routed or gated wrongly raises the wrong one of the four outputs in the same cycle the occupancy changes.

// File: rtl/tfq_pkg.sv
package tfq_pkg;
   localparam int THR_W = 5;

   typedef struct packed {
      logic             rx_en;
      logic [THR_W-1:0] hi_thr;
      logic             tx_en;
      logic [THR_W-1:0] lo_thr;
   } tfq_cfg_t;

   function automatic tfq_cfg_t unpack_cfg(input logic [15:0] v);
      tfq_cfg_t c;
      c.rx_en  = v[15];
      c.hi_thr = v[12:8];
      c.tx_en  = v[7];
      c.lo_thr = v[4:0];
      return c;
   endfunction

   function automatic logic [15:0] pack_cfg(input tfq_cfg_t c);
      return {c.rx_en, 2'b00, c.hi_thr, c.tx_en, 2'b00, c.lo_thr};
   endfunction
endpackage

// File: rtl/tfq_cfg.sv
module tfq_cfg
   import tfq_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  logic [15:0] wdata,
   output tfq_cfg_t    cfg,
   output logic [15:0] rdata
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg.rx_en  <= 1'b0;
         cfg.hi_thr <= '1;
         cfg.tx_en  <= 1'b0;
         cfg.lo_thr <= '0;
      end else if (we) begin
         cfg <= unpack_cfg(wdata);
      end
   end

   assign rdata = pack_cfg(cfg);
endmodule

// File: rtl/tfq_ctrl.sv
module tfq_ctrl #(
   parameter int AW = 5,
   localparam int DEPTH = 1 << AW,
   localparam int LW = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          push_req,
   input  logic          pop_req,
   output logic          do_push,
   output logic          do_pop,
   output logic [AW-1:0] wr_ptr,
   output logic [AW-1:0] rd_ptr,
   output logic [LW-1:0] level
);
   logic is_full, is_empty;

   assign is_full  = (level == LW'(DEPTH));
   assign is_empty = (level == '0);
   assign do_push  = push_req & ~is_full & ~clear;
   assign do_pop   = pop_req & ~is_empty & ~clear;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/tfq_mem.sv
module tfq_mem #(
   parameter int AW = 5,
   parameter int DW = 16,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] words [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)
            words[i] <= '0;
         else if (we && waddr == AW'(i))
            words[i] <= wdata;
      end
   end

   assign rdata = words[raddr];
endmodule

// File: rtl/tfq_thresh.sv
module tfq_thresh
   import tfq_pkg::*;
#(
   parameter int LW = 6,
   localparam int CW = (LW > THR_W) ? LW + 1 : THR_W + 1
) (
   input  tfq_cfg_t      cfg,
   input  logic [LW-1:0] level,
   input  logic          dir_rx,
   input  logic          xfer_active,
   output logic          rx_dma_req,
   output logic          tx_dma_req,
   output logic          full_flag,
   output logic          empty_flag
);
   logic [CW-1:0] lvl_x, hi_x, lo_x;
   logic          live, above, below;

   assign lvl_x = CW'(level);
   assign hi_x  = CW'(cfg.hi_thr);
   assign lo_x  = CW'(cfg.lo_thr);
   assign live  = xfer_active | (level != '0);
   assign above = live &  dir_rx & (lvl_x > hi_x);
   assign below = live & ~dir_rx & (lvl_x < lo_x);

   assign rx_dma_req = above &  cfg.rx_en;
   assign full_flag  = above & ~cfg.rx_en;
   assign tx_dma_req = below &  cfg.tx_en;
   assign empty_flag = below & ~cfg.tx_en;
endmodule

// File: rtl/tfifo_dma.sv
module tfifo_dma
   import tfq_pkg::*;
#(
   parameter int AW = 5,
   parameter int DW = 16,
   localparam int LW = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [15:0]   cfg_wdata,
   output logic [15:0]   cfg_rdata,
   input  logic          bus_wr,
   input  logic [DW-1:0] bus_wdata,
   input  logic          bus_rd,
   input  logic          card_push,
   input  logic [DW-1:0] card_wdata,
   input  logic          card_pop,
   output logic [DW-1:0] rd_data,
   input  logic          dir_rx,
   input  logic          xfer_active,
   input  logic          cmd_start,
   output logic [LW-1:0] level,
   output logic          rx_dma_req,
   output logic          tx_dma_req,
   output logic          full_flag,
   output logic          empty_flag
);
   if (AW < 2 || AW > THR_W) begin : g_bad_aw
      $error("tfifo_dma: AW out of range");
   end
   if (DW < 1) begin : g_bad_dw
      $error("tfifo_dma: DW must be positive");
   end

   tfq_cfg_t      cfg;
   logic          do_push, do_pop;
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [DW-1:0] push_word;

   assign push_word = bus_wr ? bus_wdata : card_wdata;

   tfq_cfg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .cfg   (cfg),
      .rdata (cfg_rdata)
   );

   tfq_ctrl #(.AW(AW)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (cmd_start),
      .push_req (bus_wr | card_push),
      .pop_req  (bus_rd | card_pop),
      .do_push  (do_push),
      .do_pop   (do_pop),
      .wr_ptr   (wr_ptr),
      .rd_ptr   (rd_ptr),
      .level    (level)
   );

   tfq_mem #(.AW(AW), .DW(DW)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (do_push),
      .waddr (wr_ptr),
      .wdata (push_word),
      .raddr (rd_ptr),
      .rdata (rd_data)
   );

   tfq_thresh #(.LW(LW)) u_thr (
      .cfg         (cfg),
      .level       (level),
      .dir_rx      (dir_rx),
      .xfer_active (xfer_active),
      .rx_dma_req  (rx_dma_req),
      .tx_dma_req  (tx_dma_req),
      .full_flag   (full_flag),
      .empty_flag  (empty_flag)
   );
endmodule

// File: rtl/tfifo_dma_chk.sv
module tfifo_dma_chk #(
   parameter int AW = 5,
   localparam int LW = AW + 1,
   localparam int DEPTH = 1 << AW
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_we,
   input logic [15:0]   cfg_wdata,
   input logic          push_any,
   input logic          pop_any,
   input logic          cmd_start,
   input logic          xfer_active,
   input logic [LW-1:0] level,
   input logic          rx_dma_req,
   input logic          tx_dma_req,
   input logic          full_flag,
   input logic          empty_flag
);
   // R3: occupancy bounded by the depth
   p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));
   // R3: full buffer rejects a lone push
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (level == LW'(DEPTH) && push_any && !pop_any && !cmd_start) |=> level == LW'(DEPTH));
   // R4: empty buffer ignores a lone pop
   p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (level == '0 && pop_any && !push_any && !cmd_start) |=> level == '0);
   // R2: an accepted lone push adds exactly one
   p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (level < LW'(DEPTH) && push_any && !pop_any && !cmd_start) |=> level == $past(level) + 1'b1);
   // R9: command start empties the buffer
   p_cmd_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |=> level == '0);
   // R7: idle and empty means all threshold outputs quiet
   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_active && level == '0) |-> !(rx_dma_req || tx_dma_req || full_flag || empty_flag));
   // R8: enabling RX DMA clears the almost-full flag
   p_rx_en_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_wdata[15]) |=> !full_flag);
   // R8: enabling TX DMA clears the almost-empty flag
   p_tx_en_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_wdata[7]) |=> !empty_flag);
   // R5, R6: at most one threshold output at a time
   p_one_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_dma_req, tx_dma_req, full_flag, empty_flag}));
endmodule

bind tfifo_dma tfifo_dma_chk #(.AW(AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_we      (cfg_we),
   .cfg_wdata   (cfg_wdata),
   .push_any    (bus_wr | card_push),
   .pop_any     (bus_rd | card_pop),
   .cmd_start   (cmd_start),
   .xfer_active (xfer_active),
   .level       (level),
   .rx_dma_req  (rx_dma_req),
   .tx_dma_req  (tx_dma_req),
   .full_flag   (full_flag),
   .empty_flag  (empty_flag)
);

// File: tb/tb_tfifo_dma.sv
`timescale 1ns/1ps
module tb_tfifo_dma;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic        card_push = 1'b0;
   logic [15:0] card_wdata = '0;
   logic        card_pop = 1'b0;
   logic [15:0] rd_data;
   logic        dir_rx = 1'b0;
   logic        xfer_active = 1'b0;
   logic        cmd_start = 1'b0;
   logic [5:0]  level;
   logic        rx_dma_req, tx_dma_req, full_flag, empty_flag;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   tfifo_dma dut (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one clock: inputs already set at a negedge; returns at next negedge with strobes cleared
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      cfg_we = 0; bus_wr = 0; bus_rd = 0; card_push = 0; card_pop = 0; cmd_start = 0;
   endtask

   task automatic write_cfg(input logic [15:0] v);
      cfg_we = 1; cfg_wdata = v; tick();
   endtask

   task automatic restart();
      cmd_start = 1; tick();
   endtask

   function automatic logic [3:0] outs();
      return {rx_dma_req, full_flag, tx_dma_req, empty_flag};
   endfunction

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int hi_list[4] = '{0, 7, 30, 31};
      int lo_list[4] = '{0, 1, 17, 31};
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      check("R1 level", level, 0);
      check("R1 cfg", cfg_rdata, 16'h1F00);
      check("R1 outs", outs(), 0);

      // R8 readback mask
      write_cfg(16'hFFFF);
      check("R8 readback all", cfg_rdata, 16'h9F9F);
      write_cfg(16'h8A65);
      check("R8 readback mix", cfg_rdata, 16'h8A65 & 16'h9F9F);

      // R5 receive sweep and R3 full drop
      dir_rx = 1; xfer_active = 1;
      foreach (hi_list[h]) begin
         for (int en = 0; en < 2; en++) begin
            restart();
            write_cfg({en[0], 2'b00, hi_list[h][4:0], 8'h00});
            for (int n = 0; n <= 32; n++) begin
               logic ab;
               ab = n > hi_list[h];
               check("R5 level", level, n);
               check("R5 outs", outs(), {ab & en[0], ab & ~en[0], 2'b00});
               card_push = 1; card_wdata = 16'(n); tick();
            end
            check("R3 full drop", level, 32);
            card_push = 1; card_pop = 1; card_wdata = 16'hDEAD; tick();
            check("R3 full push+pop", level, 31);
         end
      end

      // R6 transmit sweep with R2 order
      dir_rx = 0;
      foreach (lo_list[l]) begin
         for (int en = 0; en < 2; en++) begin
            restart();
            write_cfg({8'h1F, en[0], 2'b00, lo_list[l][4:0]});
            for (int k = 0; k < 32; k++) begin
               bus_wr = 1; bus_wdata = 16'(16'h1000 * l + 16'h100 * en + k); tick();
            end
            for (int n = 32; n >= 0; n--) begin
               logic bl;
               bl = n < lo_list[l];
               check("R6 level", level, n);
               check("R6 outs", outs(), {2'b00, bl & en[0], bl & ~en[0]});
               if (n > 0) begin
                  check("R2 order", rd_data, 16'h1000 * l + 16'h100 * en + (32 - n));
                  card_pop = 1; tick();
               end
            end
         end
      end

      // R4 read when empty: head is slot 0 = first word of last fill
      check("R4 head", rd_data, 16'h1000 * 3 + 16'h100 + 0);
      bus_rd = 1; tick();
      check("R4 no pop", level, 0);
      check("R4 head kept", rd_data, 16'h3100);
      card_pop = 1; tick();
      check("R4 card no pop", level, 0);

      // R2 wrap: offset pointers by 20 then push/pop 32 ordered words
      restart();
      for (int k = 0; k < 20; k++) begin card_push = 1; card_wdata = 16'(k); tick(); end
      for (int k = 0; k < 20; k++) begin bus_rd = 1; tick(); end
      for (int k = 0; k < 32; k++) begin card_push = 1; card_wdata = 16'(16'hA000 + k); tick(); end
      check("R2 wrap level", level, 32);
      for (int k = 0; k < 32; k++) begin
         check("R2 wrap order", rd_data, 16'hA000 + k);
         bus_rd = 1; tick();
      end
      check("R2 wrap empty", level, 0);

      // R7 idle gating
      write_cfg(16'h1F1F);
      xfer_active = 0; dir_rx = 0;
      @(negedge clk);
      check("R7 idle quiet", outs(), 0);
      bus_wr = 1; bus_wdata = 16'h0055; tick();
      check("R7 nonempty live", outs(), 4'b0001);
      bus_rd = 1; tick();
      check("R7 idle again", outs(), 0);

      // R8 enable clears flag
      xfer_active = 1;
      @(negedge clk);
      check("R8 flag before", outs(), 4'b0001);
      write_cfg(16'h1F9F);
      check("R8 tx flag cleared", outs(), 4'b0010);
      dir_rx = 1; write_cfg(16'h001F);
      for (int k = 0; k < 2; k++) begin card_push = 1; card_wdata = 16'(k); tick(); end
      check("R8 rx flag before", outs(), 4'b0100);
      write_cfg(16'h801F);
      check("R8 rx flag cleared", outs(), 4'b1000);

      // R9 command start
      restart();
      for (int k = 0; k < 5; k++) begin card_push = 1; card_wdata = 16'(k); tick(); end
      check("R9 pre level", level, 5);
      cmd_start = 1; card_push = 1; card_wdata = 16'h7777; tick();
      check("R9 cleared", level, 0);
      bus_wr = 1; bus_wdata = 16'h4242; tick();
      check("R9 fresh head", rd_data, 16'h4242);

      // R10 source priority and push+pop hold
      restart();
      bus_wr = 1; bus_wdata = 16'hB0B0; card_push = 1; card_wdata = 16'hC0C0; tick();
      check("R10 one word", level, 1);
      check("R10 bus wins", rd_data, 16'hB0B0);
      card_push = 1; card_wdata = 16'h0002; tick();
      card_push = 1; card_wdata = 16'h0003; tick();
      bus_wr = 1; bus_wdata = 16'h0004; bus_rd = 1; tick();
      check("R10 push+pop level", level, 3);
      check("R10 push+pop head", rd_data, 16'h0002);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule